// File: doc/BRIEF.md
# CAN Standby Wake-up Detector

This block is the digital control for the low-power path of a high-speed CAN line driver. A mode-select input picks between a standby mode, where only a low-power bus comparator watches the wires, and a normal mode, where the full receiver and the transmitter are in use. The block synchronizes the mode input and the low-power comparator output with two flops each. It drives the enable signals for the transmitter, the main receiver and the low-power monitor, and it produces the receive-data output seen by the protocol controller.

In standby, bus activity is measured in clock cycles. A dominant level has to last a full filter time before a wake request is reported. The report is a low level on receive data, and it is not latched. Receive data goes high again a release delay after the bus returns to recessive, but only once a minimum low pulse width has been met. In normal mode, receive data is the inverted main receiver output with no register in the path. After normal mode is selected, the transmitter is enabled only when a settle count has run out.

Top module: `canstb_wake_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, the block is in standby: `rxd_o`=1, `tx_en_o`=0, `rx_en_o`=0, `lp_mon_en_o`=1.
- R2: `stby_sel_i`=1 selects standby (`rx_en_o`=0, `tx_en_o`=0, `lp_mon_en_o`=1). `stby_sel_i`=0 selects normal (`rx_en_o`=1, `lp_mon_en_o`=0). A change appears on these outputs two clock cycles after it is applied.
- R3: In standby, when `lp_dom_i`=1 (dominant) is held for at least WAKE_FILT_CYC cycles, `rxd_o` goes low exactly WAKE_FILT_CYC+2 cycles after the dominant level was applied.
- R4: In standby, a dominant level lasting fewer than WAKE_FILT_CYC cycles leaves `rxd_o` high.
- R5: A recessive sample seen before the filter count is complete restarts the count, so two short dominant runs separated by a gap do not wake the block.
- R6: The wake indication is not latched. Once the minimum width has been met, `rxd_o` returns high exactly WAKE_REL_CYC+2 cycles after `lp_dom_i` returns to 0.
- R7: A wake low pulse on `rxd_o` lasts at least WAKE_MIN_LOW_CYC cycles, even if the bus is released earlier.
- R8: A dominant sample during the release count restarts that count. The release delay is measured from the last return to recessive.
- R9: In normal mode, `rxd_o` equals the inverse of `main_dom_i`, combinationally.
- R10: `tx_en_o` goes high STB_TO_NORM_CYC+2 cycles after `stby_sel_i` falls. It goes low two cycles after `stby_sel_i` rises.
- R11: If normal mode is selected while a wake is being indicated, the wake state is dropped, and `rxd_o` follows `main_dom_i` two cycles after `stby_sel_i` falls.
- R12: In standby with no wake request, `rxd_o` stays high whatever the value of `main_dom_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_sel_i | input | 1 | Mode select, asynchronous: 1 = standby, 0 = normal |
| lp_dom_i | input | 1 | Low-power bus comparator, asynchronous: 1 = dominant |
| main_dom_i | input | 1 | Main receiver output: 1 = dominant |
| rxd_o | output | 1 | Receive data to the protocol controller: low = dominant or wake |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Main receiver enable |
| lp_mon_en_o | output | 1 | Low-power bus monitor enable |

## Verification
Every asynchronous input reaches the logic two edges after it is applied. Mode-driven enables therefore change on the second cycle. A wake report is due at WAKE_FILT_CYC+2 cycles, its release at WAKE_REL_CYC+2 cycles after the last return to recessive (or at WAKE_FILT_CYC+2+WAKE_MIN_LOW_CYC if that is later), and the transmitter enable at STB_TO_NORM_CYC+2 cycles. The bench drives on falling edges, counts falling edges from the stimulus, and records the first cycle in which `rxd_o` changes, so each result is compared against the exact cycle. Where possible, one cycle before the due cycle is checked as well. The normal-mode receive path has no register, so it is checked a moment after its input is driven, without waiting for a clock.

// File: rtl/canstb_pkg.sv
package canstb_pkg;

    typedef enum logic {
        MODE_NORMAL  = 1'b0,
        MODE_STANDBY = 1'b1
    } cs_mode_e;

    // bits needed to hold the values 0 .. span-1
    function automatic int cnt_width(input int span);
        return (span <= 2) ? 1 : $clog2(span);
    endfunction

endpackage

// File: rtl/canstb_sync.sv
module canstb_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] held;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta = async_i;
        st_d.held = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{meta: RST_VAL, held: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.held;

endmodule

// File: rtl/canstb_wake_filter.sv
module canstb_wake_filter
    import canstb_pkg::*;
#(
    parameter int WAKE_FILT_CYC    = 100,
    parameter int WAKE_REL_CYC     = 150,
    parameter int WAKE_MIN_LOW_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_i,
    input  logic dom_i,
    output logic wake_o
);

    localparam int DW = cnt_width(WAKE_FILT_CYC);
    localparam int RW = cnt_width(WAKE_REL_CYC);
    localparam int LW = cnt_width(WAKE_MIN_LOW_CYC);
    localparam logic [DW-1:0] DOM_LAST = DW'(WAKE_FILT_CYC - 1);
    localparam logic [RW-1:0] REL_LAST = RW'(WAKE_REL_CYC - 1);
    localparam logic [LW-1:0] LOW_LAST = LW'(WAKE_MIN_LOW_CYC - 1);

    typedef struct packed {
        logic          wake;
        logic [DW-1:0] dom_cnt;
        logic [RW-1:0] rel_cnt;
        logic [LW-1:0] low_cnt;
    } wf_st_t;

    wf_st_t st_d, st_q;
    logic   low_ok;

    always_comb begin
        st_d   = st_q;
        low_ok = (st_q.low_cnt == LOW_LAST);
        if (!stby_i) begin
            // normal mode: the standby path is idle
            st_d = '0;
        end else if (!st_q.wake) begin
            st_d.rel_cnt = '0;
            st_d.low_cnt = '0;
            if (!dom_i) begin
                st_d.dom_cnt = '0;
            end else if (st_q.dom_cnt == DOM_LAST) begin
                st_d.wake    = 1'b1;
                st_d.dom_cnt = '0;
            end else begin
                st_d.dom_cnt = st_q.dom_cnt + 1'b1;
            end
        end else begin
            if (!low_ok) begin
                st_d.low_cnt = st_q.low_cnt + 1'b1;
            end
            if (dom_i) begin
                st_d.rel_cnt = '0;
            end else if (st_q.rel_cnt == REL_LAST) begin
                if (low_ok) begin
                    st_d.wake    = 1'b0;
                    st_d.rel_cnt = '0;
                    st_d.low_cnt = '0;
                end
            end else begin
                st_d.rel_cnt = st_q.rel_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_o = st_q.wake;

endmodule

// File: rtl/canstb_mode_seq.sv
module canstb_mode_seq
    import canstb_pkg::*;
#(
    parameter int STB_TO_NORM_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_i,
    output logic tx_ready_o
);

    localparam int NW = cnt_width(STB_TO_NORM_CYC);
    localparam logic [NW-1:0] NM_LAST = NW'(STB_TO_NORM_CYC - 1);

    typedef struct packed {
        logic          ready;
        logic [NW-1:0] cnt;
    } ms_st_t;

    ms_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stby_i) begin
            st_d = '0;
        end else if (!st_q.ready) begin
            if (st_q.cnt == NM_LAST) begin
                st_d.ready = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_ready_o = st_q.ready;

endmodule

// File: rtl/canstb_wake_ctrl.sv
module canstb_wake_ctrl
    import canstb_pkg::*;
#(
    parameter int WAKE_FILT_CYC    = 100,
    parameter int WAKE_REL_CYC     = 150,
    parameter int WAKE_MIN_LOW_CYC = 25,
    parameter int STB_TO_NORM_CYC  = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_sel_i,
    input  logic lp_dom_i,
    input  logic main_dom_i,
    output logic rxd_o,
    output logic tx_en_o,
    output logic rx_en_o,
    output logic lp_mon_en_o
);

    logic [1:0] sync_vec;
    logic       stby_s;
    logic       dom_s;
    logic       wake_ind;
    logic       tx_ready;
    cs_mode_e   mode;

    // bit 1: mode select (pulled to standby), bit 0: bus comparator
    canstb_sync #(
        .WIDTH   (2),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({stby_sel_i, lp_dom_i}),
        .sync_o  (sync_vec)
    );

    assign stby_s = sync_vec[1];
    assign dom_s  = sync_vec[0];
    assign mode   = cs_mode_e'(stby_s);

    canstb_wake_filter #(
        .WAKE_FILT_CYC    (WAKE_FILT_CYC),
        .WAKE_REL_CYC     (WAKE_REL_CYC),
        .WAKE_MIN_LOW_CYC (WAKE_MIN_LOW_CYC)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .stby_i (stby_s),
        .dom_i  (dom_s),
        .wake_o (wake_ind)
    );

    canstb_mode_seq #(
        .STB_TO_NORM_CYC (STB_TO_NORM_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stby_i     (stby_s),
        .tx_ready_o (tx_ready)
    );

    always_comb begin
        rx_en_o     = (mode == MODE_NORMAL);
        lp_mon_en_o = (mode == MODE_STANDBY);
        tx_en_o     = tx_ready && (mode == MODE_NORMAL);
        rxd_o       = (mode == MODE_NORMAL) ? ~main_dom_i : ~wake_ind;
    end

endmodule

// File: rtl/canstb_wake_chk.sv
module canstb_wake_chk
    import canstb_pkg::*;
#(
    parameter int WAKE_MIN_LOW_CYC = 25,
    parameter int STB_TO_NORM_CYC  = 500
) (
    input logic clk,
    input logic rst_n,
    input logic dom_s,
    input logic wake_ind,
    input logic rxd_o,
    input logic tx_en_o,
    input logic rx_en_o,
    input logic lp_mon_en_o
);

    localparam int LCW = cnt_width(WAKE_MIN_LOW_CYC + 1);
    localparam int NCW = cnt_width(STB_TO_NORM_CYC + 1);

    logic [LCW-1:0] low_run;
    logic [NCW-1:0] norm_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run  <= '0;
            norm_run <= '0;
        end else begin
            if (!wake_ind) low_run <= '0;
            else if (low_run != LCW'(WAKE_MIN_LOW_CYC)) low_run <= low_run + 1'b1;
            if (!rx_en_o) norm_run <= '0;
            else if (norm_run != NCW'(STB_TO_NORM_CYC)) norm_run <= norm_run + 1'b1;
        end
    end

    // R3
    wake_needs_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_ind) |-> $past(dom_s));

    // R6
    release_on_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wake_ind) && lp_mon_en_o) |-> !$past(dom_s));

    // R7
    min_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wake_ind) && lp_mon_en_o) |-> (low_run >= LCW'(WAKE_MIN_LOW_CYC)));

    // R10
    tx_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> (norm_run >= NCW'(STB_TO_NORM_CYC)));

    // R11
    wake_drop_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en_o && $past(rx_en_o)) |-> !wake_ind);

    // R12
    idle_rxd_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mon_en_o && !wake_ind) |-> rxd_o);

endmodule

bind canstb_wake_ctrl canstb_wake_chk #(
    .WAKE_MIN_LOW_CYC (WAKE_MIN_LOW_CYC),
    .STB_TO_NORM_CYC  (STB_TO_NORM_CYC)
) u_wake_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dom_s       (dom_s),
    .wake_ind    (wake_ind),
    .rxd_o       (rxd_o),
    .tx_en_o     (tx_en_o),
    .rx_en_o     (rx_en_o),
    .lp_mon_en_o (lp_mon_en_o)
);

// File: tb/canstb_wake_ctrl_bench.sv
module canstb_wake_ctrl_bench;

    localparam int FILT = 8;
    localparam int REL  = 5;
    localparam int MINL = 20;
    localparam int NM   = 12;

    typedef struct packed {
        logic [7:0] len;
        logic       wake;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{len: 8'd1,  wake: 1'b0},
        '{len: 8'd7,  wake: 1'b0},
        '{len: 8'd8,  wake: 1'b1},
        '{len: 8'd9,  wake: 1'b1},
        '{len: 8'd30, wake: 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic stby_sel_i, lp_dom_i, main_dom_i;
    logic rxd_o, tx_en_o, rx_en_o, lp_mon_en_o;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    canstb_wake_ctrl #(
        .WAKE_FILT_CYC    (FILT),
        .WAKE_REL_CYC     (REL),
        .WAKE_MIN_LOW_CYC (MINL),
        .STB_TO_NORM_CYC  (NM)
    ) u_canstb_wake_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .stby_sel_i  (stby_sel_i),
        .lp_dom_i    (lp_dom_i),
        .main_dom_i  (main_dom_i),
        .rxd_o       (rxd_o),
        .tx_en_o     (tx_en_o),
        .rx_en_o     (rx_en_o),
        .lp_mon_en_o (lp_mon_en_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int actual, input int expected);
        n_total++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int first_low;
        int first_high;
        int exp_high;
        bit any_low;

        rst_n = 1'b0; stby_sel_i = 1'b1; lp_dom_i = 1'b0; main_dom_i = 1'b0;
        tick(3);
        // R1 reset state
        check("R1 rxd", rxd_o, 1);
        check("R1 tx_en", tx_en_o, 0);
        check("R1 rx_en", rx_en_o, 0);
        check("R1 lp_mon_en", lp_mon_en_o, 1);
        rst_n = 1'b1;
        tick(3);
        check("R1 rxd after release", rxd_o, 1);

        // vector table: R3 R4 R6 R7
        for (int v = 0; v < NV; v++) begin
            first_low = 0;
            first_high = 0;
            lp_dom_i = 1'b1;
            for (int k = 1; k <= int'(VEC[v].len) + 60; k++) begin
                tick(1);
                if (!rxd_o && first_low == 0) first_low = k;
                if (rxd_o && first_low != 0 && first_high == 0) first_high = k;
                if (k == int'(VEC[v].len)) lp_dom_i = 1'b0;
            end
            if (VEC[v].wake) begin
                check("R3 wake low cycle", first_low, FILT + 2);
                exp_high = int'(VEC[v].len) + REL + 2;
                if (exp_high < FILT + 2 + MINL) begin
                    check("R7 min low release cycle", first_high, FILT + 2 + MINL);
                end else begin
                    check("R6 release cycle", first_high, exp_high);
                end
            end else begin
                check("R4 short pulse ignored", first_low, 0);
            end
        end

        // R5 recessive gap restarts the filter
        any_low = 1'b0;
        lp_dom_i = 1'b1;
        for (int k = 1; k <= 44; k++) begin
            tick(1);
            if (!rxd_o) any_low = 1'b1;
            if (k == 6)  lp_dom_i = 1'b0;
            if (k == 8)  lp_dom_i = 1'b1;
            if (k == 14) lp_dom_i = 1'b0;
        end
        check("R5 split dominant no wake", any_low, 0);

        // R12 main receiver ignored in standby
        main_dom_i = 1'b1;
        tick(5);
        check("R12 standby rxd high", rxd_o, 1);
        main_dom_i = 1'b0;

        // R8 dominant during release restarts it
        first_low = 0;
        first_high = 0;
        lp_dom_i = 1'b1;
        for (int k = 1; k <= 80; k++) begin
            tick(1);
            if (!rxd_o && first_low == 0) first_low = k;
            if (rxd_o && first_low != 0 && first_high == 0) first_high = k;
            if (k == 40) lp_dom_i = 1'b0;
            if (k == 43) lp_dom_i = 1'b1;
            if (k == 45) lp_dom_i = 1'b0;
        end
        check("R8 release restarted", first_high, 45 + REL + 2);

        // R2 / R10 entering normal mode
        stby_sel_i = 1'b0;
        tick(1);
        check("R2 rx_en one cycle", rx_en_o, 0);
        tick(1);
        check("R2 rx_en two cycles", rx_en_o, 1);
        check("R2 lp_mon_en off", lp_mon_en_o, 0);
        tick(NM - 1);
        check("R10 tx_en before settle", tx_en_o, 0);
        tick(1);
        check("R10 tx_en after settle", tx_en_o, 1);

        // R9 normal pass-through
        main_dom_i = 1'b1;
        #1;
        check("R9 dominant rxd", rxd_o, 0);
        main_dom_i = 1'b0;
        #1;
        check("R9 recessive rxd", rxd_o, 1);
        lp_dom_i = 1'b1;
        #1;
        check("R9 lp comparator ignored", rxd_o, 1);
        lp_dom_i = 1'b0;

        // R10 / R2 back to standby
        tick(1);
        stby_sel_i = 1'b1;
        tick(1);
        check("R10 tx_en held one cycle", tx_en_o, 1);
        tick(1);
        check("R10 tx_en dropped", tx_en_o, 0);
        check("R2 lp_mon_en back", lp_mon_en_o, 1);
        tick(5);

        // R11 normal selected during wake
        lp_dom_i = 1'b1;
        tick(15);
        check("R3 wake shown", rxd_o, 0);
        stby_sel_i = 1'b0;
        tick(1);
        check("R11 still wake one cycle", rxd_o, 0);
        tick(1);
        check("R11 follows main receiver", rxd_o, 1);
        main_dom_i = 1'b1;
        #1;
        check("R11 main dominant", rxd_o, 0);
        main_dom_i = 1'b0;
        lp_dom_i = 1'b0;
        stby_sel_i = 1'b1;
        tick(5);
        check("R12 idle after return", rxd_o, 1);

        finish_run();
    end

endmodule